// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the control decoder of a single-cycle processor datapath. It looks at the 6-bit major opcode and the 6-bit function field of the instruction being executed. From these it produces every steering and enable signal that the datapath needs within the same cycle. Those signals select the destination register field, select the second ALU operand, give the ALU a 3-bit operation code, choose whether data memory or the ALU feeds the write-back, and enable the register file write, memory read and memory write. The decoder has no state: its outputs follow its inputs combinationally.

The ALU code is chosen directly for each instruction, with no second decoding stage in front of the ALU. The decoder also flags branch instructions. It combines that flag with the ALU's equality (zero) result to produce the next-PC select, which picks between the sequential address and the branch target. An opcode it does not recognise turns into a harmless no-operation with every enable low. An unrecognised function code under the register-form opcode is handled the same way.

Top module: `ctl_main_decoder`

## Requirements
- R1: Register-form instructions (opcode 0x00) with a known function code drive dst_sel_rt=0, alu_src_imm=0, wb_from_mem=0, reg_we=1, mem_re=0, mem_we=0, is_branch=0.
- R2: alu_op encodes the operation as 000 add, 001 subtract, 010 and, 011 or, 100 set-less-than. Register form uses function codes 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x2A slt.
- R3: Immediate forms drive dst_sel_rt=1, alu_src_imm=1, reg_we=1, wb_from_mem=0, mem_re=0, mem_we=0, is_branch=0. The opcodes are 0x08 add, 0x18 subtract, 0x0C and, 0x0D or and 0x0A set-less-than.
- R4: Load (opcode 0x23) drives dst_sel_rt=1, alu_src_imm=1, alu_op=000, wb_from_mem=1, reg_we=1, mem_re=1, mem_we=0, is_branch=0.
- R5: Store (opcode 0x2B) drives alu_src_imm=1, alu_op=000, mem_we=1 and every other output 0.
- R6: Branch-if-equal (opcode 0x04) drives alu_op=001 and is_branch=1, with every write and read enable 0 and both source/destination selects 0.
- R7: pc_sel_target is 1 exactly when is_branch=1 and alu_zero=1. For every other instruction, alu_zero has no effect on any output.
- R8: Any opcode not listed in R1 to R6 drives every output to 0.
- R9: Opcode 0x00 with a function code not listed in R2 drives every output to 0.
- R10: For every opcode other than 0x00, the function field has no effect on any output.
- R11: mem_re and mem_we are never both 1, and mem_we=1 never coincides with reg_we=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opc_field | input | 6 | Major opcode of the current instruction |
| fn_field | input | 6 | Function field of the current instruction |
| alu_zero | input | 1 | ALU result-equals-zero flag |
| dst_sel_rt | output | 1 | 1: destination register from the second source field; 0: from the third field |
| alu_src_imm | output | 1 | 1: ALU second operand is the extended immediate |
| alu_op | output | 3 | ALU operation code |
| is_branch | output | 1 | Instruction is a conditional branch |
| wb_from_mem | output | 1 | 1: write-back data from data memory |
| reg_we | output | 1 | Register file write enable |
| mem_re | output | 1 | Data memory read enable |
| mem_we | output | 1 | Data memory write enable |
| pc_sel_target | output | 1 | 1: next PC is the branch target |

## Verification
The decoder is driven with each register-form function code and with filler values in the function field, which separates the five ALU codes from one another. It is also driven with each immediate opcode, which shows that the operand and destination selects flip while the ALU code stays the same as the register form. Load, store and branch are each applied with both values of the zero flag, which shows that only the branch reacts to that flag. A sweep of all 64 opcodes, each with several function codes and both zero values, shows that unknown opcodes and unknown register-form function codes stay silent and that the function field matters only under opcode 0x00.

// File: rtl/ctl_pkg.sv
// Package: shared widths, encodings and types for the instruction control decoder.
// Assumes a 6-bit opcode, a 6-bit function field and a 3-bit ALU operation code.
package ctl_pkg;

    parameter int OPC_W = 6;
    parameter int FN_W  = 6;
    parameter int AOP_W = 3;

    // ALU operation codes seen by the datapath ALU.
    typedef enum logic [AOP_W-1:0] {
        AOP_ADD = 3'd0,
        AOP_SUB = 3'd1,
        AOP_AND = 3'd2,
        AOP_OR  = 3'd3,
        AOP_SLT = 3'd4
    } aop_e;

    // Major opcode values.
    localparam logic [OPC_W-1:0] OPC_REGFORM = 6'h00;
    localparam logic [OPC_W-1:0] OPC_BREQ    = 6'h04;
    localparam logic [OPC_W-1:0] OPC_ADDI    = 6'h08;
    localparam logic [OPC_W-1:0] OPC_SLTI    = 6'h0A;
    localparam logic [OPC_W-1:0] OPC_ANDI    = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_ORI     = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_SUBI    = 6'h18;
    localparam logic [OPC_W-1:0] OPC_LOAD    = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE   = 6'h2B;

    // Function field values under the register-form opcode.
    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    // Instruction class produced by the opcode stage.
    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_REG    = 3'd1,
        CLS_IMM    = 3'd2,
        CLS_LOAD   = 3'd3,
        CLS_STORE  = 3'd4,
        CLS_BRANCH = 3'd5
    } icls_e;

    // Full control word for the datapath.
    typedef struct packed {
        logic dst_rt;
        logic src_imm;
        aop_e aop;
        logic branch;
        logic wb_mem;
        logic rf_we;
        logic dm_re;
        logic dm_we;
    } ctl_t;

endpackage

// File: rtl/ctl_opcode_dec.sv
// Opcode stage: classifies the major opcode and, for immediate forms,
// picks the ALU operation. Assumes opcode encodings from ctl_pkg.
module ctl_opcode_dec
    import ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output icls_e            cls,
    output aop_e             imm_aop
);

    // Map each opcode to its class and immediate ALU operation.
    always_comb begin
        cls     = CLS_NONE;
        imm_aop = AOP_ADD;
        case (opc)
            OPC_REGFORM: cls = CLS_REG;
            OPC_ADDI:    begin cls = CLS_IMM; imm_aop = AOP_ADD; end
            OPC_SUBI:    begin cls = CLS_IMM; imm_aop = AOP_SUB; end
            OPC_ANDI:    begin cls = CLS_IMM; imm_aop = AOP_AND; end
            OPC_ORI:     begin cls = CLS_IMM; imm_aop = AOP_OR;  end
            OPC_SLTI:    begin cls = CLS_IMM; imm_aop = AOP_SLT; end
            OPC_LOAD:    cls = CLS_LOAD;
            OPC_STORE:   cls = CLS_STORE;
            OPC_BREQ:    cls = CLS_BRANCH;
            default:     cls = CLS_NONE;
        endcase
    end

endmodule

// File: rtl/ctl_funct_dec.sv
// Function stage: turns the function field of a register-form instruction
// into an ALU operation and a validity flag. It has no knowledge of the opcode.
module ctl_funct_dec
    import ctl_pkg::*;
(
    input  logic [FN_W-1:0] fn,
    output aop_e            reg_aop,
    output logic            reg_ok
);

    // Look up the function code; unknown codes clear reg_ok.
    always_comb begin
        reg_aop = AOP_ADD;
        reg_ok  = 1'b1;
        case (fn)
            FN_ADD:  reg_aop = AOP_ADD;
            FN_SUB:  reg_aop = AOP_SUB;
            FN_AND:  reg_aop = AOP_AND;
            FN_OR:   reg_aop = AOP_OR;
            FN_SLT:  reg_aop = AOP_SLT;
            default: reg_ok  = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctl_field_gen.sv
// Control word builder: merges the class, the immediate ALU operation and the
// function-stage result into one control word. Don't-care fields are driven 0.
module ctl_field_gen
    import ctl_pkg::*;
(
    input  icls_e cls,
    input  aop_e  imm_aop,
    input  aop_e  reg_aop,
    input  logic  reg_ok,
    output ctl_t  ctl
);

    // Fill the control word for each class; anything unknown stays all-zero.
    always_comb begin
        ctl = '0;
        case (cls)
            CLS_REG: begin
                if (reg_ok) begin
                    ctl.aop   = reg_aop;
                    ctl.rf_we = 1'b1;
                end
            end
            CLS_IMM: begin
                ctl.dst_rt  = 1'b1;
                ctl.src_imm = 1'b1;
                ctl.aop     = imm_aop;
                ctl.rf_we   = 1'b1;
            end
            CLS_LOAD: begin
                ctl.dst_rt  = 1'b1;
                ctl.src_imm = 1'b1;
                ctl.aop     = AOP_ADD;
                ctl.wb_mem  = 1'b1;
                ctl.rf_we   = 1'b1;
                ctl.dm_re   = 1'b1;
            end
            CLS_STORE: begin
                ctl.src_imm = 1'b1;
                ctl.aop     = AOP_ADD;
                ctl.dm_we   = 1'b1;
            end
            CLS_BRANCH: begin
                ctl.aop    = AOP_SUB;
                ctl.branch = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/ctl_next_pc_sel.sv
// Next-PC select: requests the branch target only for a branch whose
// comparison (ALU subtract) came out zero.
module ctl_next_pc_sel (
    input  logic branch,
    input  logic zero,
    output logic take
);

    // Qualify the branch flag with the equality result.
    always_comb take = branch & zero;

endmodule

// File: rtl/ctl_main_decoder.sv
// Top: single-cycle control decoder. Purely combinational; the opcode and
// function fields must be stable for the cycle in which the instruction executes.
module ctl_main_decoder
    import ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opc_field,
    input  logic [FN_W-1:0]  fn_field,
    input  logic             alu_zero,
    output logic             dst_sel_rt,
    output logic             alu_src_imm,
    output logic [AOP_W-1:0] alu_op,
    output logic             is_branch,
    output logic             wb_from_mem,
    output logic             reg_we,
    output logic             mem_re,
    output logic             mem_we,
    output logic             pc_sel_target
);

    icls_e cls;
    aop_e  imm_aop;
    aop_e  reg_aop;
    logic  reg_ok;
    ctl_t  ctl;

    ctl_opcode_dec u_opc (
        .opc     (opc_field),
        .cls     (cls),
        .imm_aop (imm_aop)
    );

    ctl_funct_dec u_fn (
        .fn      (fn_field),
        .reg_aop (reg_aop),
        .reg_ok  (reg_ok)
    );

    ctl_field_gen u_gen (
        .cls     (cls),
        .imm_aop (imm_aop),
        .reg_aop (reg_aop),
        .reg_ok  (reg_ok),
        .ctl     (ctl)
    );

    ctl_next_pc_sel u_pc (
        .branch (ctl.branch),
        .zero   (alu_zero),
        .take   (pc_sel_target)
    );

    // Spread the control word onto the output ports.
    always_comb begin
        dst_sel_rt  = ctl.dst_rt;
        alu_src_imm = ctl.src_imm;
        alu_op      = ctl.aop;
        is_branch   = ctl.branch;
        wb_from_mem = ctl.wb_mem;
        reg_we      = ctl.rf_we;
        mem_re      = ctl.dm_re;
        mem_we      = ctl.dm_we;
    end

endmodule

// File: rtl/ctl_main_decoder_chk.sv
// Checker: port-level rules of the control decoder, bound into every instance.
// The block has no clock, so the rules are immediate checks re-evaluated on any change.
module ctl_main_decoder_chk
    import ctl_pkg::*;
(
    input logic [OPC_W-1:0] opc_field,
    input logic [FN_W-1:0]  fn_field,
    input logic             alu_zero,
    input logic             dst_sel_rt,
    input logic             alu_src_imm,
    input logic [AOP_W-1:0] alu_op,
    input logic             is_branch,
    input logic             wb_from_mem,
    input logic             reg_we,
    input logic             mem_re,
    input logic             mem_we,
    input logic             pc_sel_target
);

    logic known_opc;
    logic known_fn;
    logic all_low;

    // Recompute the recognised sets from the encodings only.
    always_comb begin
        known_opc = (opc_field == OPC_REGFORM) || (opc_field == OPC_BREQ) ||
                    (opc_field == OPC_ADDI) || (opc_field == OPC_SUBI) ||
                    (opc_field == OPC_ANDI) || (opc_field == OPC_ORI) ||
                    (opc_field == OPC_SLTI) || (opc_field == OPC_LOAD) ||
                    (opc_field == OPC_STORE);
        known_fn  = (fn_field == FN_ADD) || (fn_field == FN_SUB) ||
                    (fn_field == FN_AND) || (fn_field == FN_OR) ||
                    (fn_field == FN_SLT);
        all_low   = !dst_sel_rt && !alu_src_imm && (alu_op == '0) && !is_branch &&
                    !wb_from_mem && !reg_we && !mem_re && !mem_we && !pc_sel_target;
    end

    // Evaluate each rule whenever any port moves.
    always_comb begin
        AST_MEM_EXCLUSIVE: assert (!(mem_re && mem_we)) else $error("mem read and write together"); // R11
        AST_STORE_NO_RF: assert (!(mem_we && reg_we)) else $error("store also writes registers"); // R11
        AST_PC_NEEDS_BRANCH_ZERO: assert (pc_sel_target == (is_branch && alu_zero)) else $error("pc select mismatch"); // R7
        AST_LOAD_SHAPE: assert (!mem_re || (reg_we && wb_from_mem && alu_src_imm && alu_op == 3'd0)) else $error("load shape"); // R4
        AST_BRANCH_SHAPE: assert (!is_branch || (alu_op == 3'd1 && !reg_we && !mem_we && !mem_re)) else $error("branch shape"); // R6
        AST_UNKNOWN_OPC_SILENT: assert (known_opc || all_low) else $error("unknown opcode not silent"); // R8
        AST_UNKNOWN_FN_SILENT: assert (opc_field != OPC_REGFORM || known_fn || all_low) else $error("unknown function not silent"); // R9
        AST_REGFORM_SELECTS: assert (opc_field != OPC_REGFORM || (!dst_sel_rt && !alu_src_imm)) else $error("register form selects"); // R1
    end

endmodule

bind ctl_main_decoder ctl_main_decoder_chk u_chk (
    .opc_field     (opc_field),
    .fn_field      (fn_field),
    .alu_zero      (alu_zero),
    .dst_sel_rt    (dst_sel_rt),
    .alu_src_imm   (alu_src_imm),
    .alu_op        (alu_op),
    .is_branch     (is_branch),
    .wb_from_mem   (wb_from_mem),
    .reg_we        (reg_we),
    .mem_re        (mem_re),
    .mem_we        (mem_we),
    .pc_sel_target (pc_sel_target)
);

// File: tb/tb_ctl_main_decoder.sv
// Scoreboard bench: driver tasks apply a vector just after a rising edge and
// queue the expected control word; a monitor pops and compares at the falling edge.
module tb_ctl_main_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opc_field = '0;
    logic [5:0] fn_field = '0;
    logic       alu_zero = 1'b0;
    logic       dst_sel_rt, alu_src_imm, is_branch, wb_from_mem;
    logic       reg_we, mem_re, mem_we, pc_sel_target;
    logic [2:0] alu_op;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [10:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    ctl_main_decoder dut (
        .opc_field     (opc_field),
        .fn_field      (fn_field),
        .alu_zero      (alu_zero),
        .dst_sel_rt    (dst_sel_rt),
        .alu_src_imm   (alu_src_imm),
        .alu_op        (alu_op),
        .is_branch     (is_branch),
        .wb_from_mem   (wb_from_mem),
        .reg_we        (reg_we),
        .mem_re        (mem_re),
        .mem_we        (mem_we),
        .pc_sel_target (pc_sel_target)
    );

    // Packing order: {dst, src, op[2:0], br, wbm, rwe, mre, mwe, pcs}
    function automatic logic [10:0] pack(logic d, logic s, logic [2:0] o, logic b,
                                         logic w, logic r, logic mr, logic mw, logic p);
        return {d, s, o, b, w, r, mr, mw, p};
    endfunction

    // Expected control word written from the requirement list.
    function automatic logic [10:0] model(logic [5:0] op, logic [5:0] fn, logic z);
        case (op)
            6'h00: case (fn)                                                     // R1 R2 R9
                6'h20: return pack(0, 0, 3'd0, 0, 0, 1, 0, 0, 0);
                6'h22: return pack(0, 0, 3'd1, 0, 0, 1, 0, 0, 0);
                6'h24: return pack(0, 0, 3'd2, 0, 0, 1, 0, 0, 0);
                6'h25: return pack(0, 0, 3'd3, 0, 0, 1, 0, 0, 0);
                6'h2A: return pack(0, 0, 3'd4, 0, 0, 1, 0, 0, 0);
                default: return '0;
            endcase
            6'h08: return pack(1, 1, 3'd0, 0, 0, 1, 0, 0, 0);                    // R3
            6'h18: return pack(1, 1, 3'd1, 0, 0, 1, 0, 0, 0);
            6'h0C: return pack(1, 1, 3'd2, 0, 0, 1, 0, 0, 0);
            6'h0D: return pack(1, 1, 3'd3, 0, 0, 1, 0, 0, 0);
            6'h0A: return pack(1, 1, 3'd4, 0, 0, 1, 0, 0, 0);
            6'h23: return pack(1, 1, 3'd0, 0, 1, 1, 1, 0, 0);                    // R4
            6'h2B: return pack(0, 1, 3'd0, 0, 0, 0, 0, 1, 0);                    // R5
            6'h04: return pack(0, 0, 3'd1, 1, 0, 0, 0, 0, z);                    // R6 R7
            default: return '0;                                                  // R8
        endcase
    endfunction

    // Driver: apply one vector after a rising edge and queue its expectation.
    task automatic send(input logic [5:0] op, input logic [5:0] fn, input logic z, input string tag);
        @(posedge clk);
        #1;
        opc_field = op;
        fn_field  = fn;
        alu_zero  = z;
        sb_q.push_back('{exp: model(op, fn, z), tag: tag});
    endtask

    // Monitor: pop and compare at each falling edge while items are pending.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [10:0] act;
            it  = sb_q.pop_front();
            act = {dst_sel_rt, alu_src_imm, alu_op, is_branch, wb_from_mem,
                   reg_we, mem_re, mem_we, pc_sel_target};
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s op=%02h fn=%02h z=%0b: actual=%011b expected=%011b",
                         it.tag, opc_field, fn_field, alu_zero, act, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        logic [5:0] rfn [5];
        logic [5:0] iop [5];
        rfn = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
        iop = '{6'h08, 6'h18, 6'h0C, 6'h0D, 6'h0A};

        // Reset state: zero inputs decode as an unknown register-form function.
        send(6'h00, 6'h00, 1'b0, "R9 reset state");
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 5; i++) send(6'h00, rfn[i], 1'b0, "R1 R2 register form");
        for (int i = 0; i < 5; i++) send(6'h00, rfn[i], 1'b1, "R7 register form zero ignored");
        for (int i = 0; i < 5; i++) send(iop[i], 6'h00, 1'b0, "R3 R2 immediate form");
        for (int i = 0; i < 5; i++) send(iop[i], rfn[i], 1'b1, "R10 immediate function ignored");
        send(6'h23, 6'h00, 1'b0, "R4 load");
        send(6'h23, 6'h3F, 1'b1, "R4 load zero ignored");
        send(6'h2B, 6'h00, 1'b0, "R5 store");
        send(6'h2B, 6'h22, 1'b1, "R5 store zero ignored");
        send(6'h04, 6'h00, 1'b0, "R6 R7 branch not taken");
        send(6'h04, 6'h00, 1'b1, "R6 R7 branch taken");
        send(6'h04, 6'h2A, 1'b1, "R10 branch function ignored");
        send(6'h02, 6'h20, 1'b1, "R8 unknown opcode");
        send(6'h3F, 6'h2A, 1'b0, "R8 unknown opcode");
        send(6'h00, 6'h21, 1'b0, "R9 unknown function");
        send(6'h00, 6'h3F, 1'b1, "R9 unknown function");

        // Full opcode sweep with several function codes and both zero values.
        for (int op = 0; op < 64; op++) begin
            for (int z = 0; z < 2; z++) begin
                send(6'(op), 6'h20, 1'(z), "R8 R10 sweep add-fn");
                send(6'(op), 6'h2A, 1'(z), "R8 R10 sweep slt-fn");
                send(6'(op), 6'h07, 1'(z), "R9 R10 sweep odd-fn");
            end
        end

        // Drain the scoreboard.
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule